// File: doc/BRIEF.md
# Numerically Controlled Oscillator Output Generator

This block is a phase-accumulator oscillator. While enabled, it adds a programmable step to a 20-bit accumulator on every clock. The carry out of that addition marks a wrap event, and the accumulator keeps the remainder. With a step of S, the average wrap rate is S / 2^20 of the clock rate.

Each wrap drives an output state machine in one of two shapes:

- **Square-wave mode:** the raw level flips on every wrap.
- **Pulse mode:** each wrap starts an active pulse that lasts 2^N clocks, where N is a 3-bit select.

A polarity stage sits last and chooses which pin level counts as active. A sticky interrupt flag records wraps, and also records polarity flips made while interrupts are live. A status output mirrors the pin.

The state machine has four states:

| State | Meaning |
|---|---|
| `ST_OFF` | Module disabled |
| `ST_IDLE` | Raw level inactive |
| `ST_HOLD_HI` | Raw level active in square-wave mode |
| `ST_PULSE` | Active pulse being timed |

Transitions:

- Any state goes to `ST_OFF` when the enable is low.
- `ST_OFF` or `ST_IDLE` go to `ST_HOLD_HI` on a wrap in square-wave mode, or to `ST_PULSE` on a wrap in pulse mode.
- `ST_OFF` goes to `ST_IDLE` when enabled and no wrap occurs.
- `ST_HOLD_HI` goes to `ST_IDLE` on a wrap in square-wave mode, or restarts a pulse on a wrap in pulse mode.
- `ST_PULSE` goes to `ST_IDLE` when the pulse count expires, or on a wrap in square-wave mode. A wrap in pulse mode restarts the pulse.

Top module: `nco_wavegen`

## Requirements
- R1: While `cfg_enable`=1, the accumulator adds `cfg_step` on every clock. A wrap is the carry out of the 20-bit sum. With `cfg_step`=2^k, wraps happen on every 2^(20-k)-th clock edge after enabling, and the first one falls on edge 2^(20-k). A step of 0 never wraps.
- R2: With `cfg_pulse_mode`=0 (square-wave mode), the raw output level flips on the same clock edge at which the wrap occurs.
- R3: With `cfg_pulse_mode`=1 (pulse mode), the raw output goes active on the wrap edge and stays active for 2^N clock periods, where N=`cfg_width_sel`[2:0] (1 to 128). The result is undefined when 2^N is not shorter than the wrap period.
- R4: `cfg_invert`=0 makes high the active pin level. `cfg_invert`=1 makes low the active level. The inactive pin level therefore equals `cfg_invert`.
- R5: `irq_flag` is set on the edge of every wrap. It stays set until a clock edge with `flag_clear`=1 and no set event. A set event on the same edge as a clear leaves the flag set.
- R6: A change of `cfg_invert` between two edges sets `irq_flag` at the next edge only when `cfg_enable`=1 and `cfg_irq_enable`=1.
- R7: `irq_req` is high exactly when `irq_flag`, `cfg_enable` and `cfg_irq_enable` are all 1.
- R8: `level_status` always equals `wave_out`.
- R9: While `cfg_enable`=0, the accumulator holds its value and the pin shows the inactive level. After re-enabling, counting resumes from the held value.
- R10: After reset, the accumulator, the state machine and `irq_flag` are zero. With `cfg_invert`=0, `wave_out`, `level_status` and `irq_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Module enable |
| cfg_pulse_mode | input | 1 | 0 = square-wave mode, 1 = pulse mode |
| cfg_invert | input | 1 | Polarity: 1 makes low the active level |
| cfg_width_sel | input | 3 | Pulse width exponent N (width = 2^N clocks) |
| cfg_step | input | 20 | Accumulator increment |
| cfg_irq_enable | input | 1 | Interrupt request enable |
| flag_clear | input | 1 | Clears the sticky flag at the next edge |
| wave_out | output | 1 | Oscillator output pin |
| level_status | output | 1 | Read-only copy of the pin level |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_req | output | 1 | Gated interrupt request |

## Verification
The vector table uses several kinds of step:

- Power-of-two steps give exact 16-, 8-, 4- and 64-cycle periods. Counting active samples over a fixed window then separates square-wave from pulse shaping and catches off-by-one edge placement.
- A step of 3·2^16 makes the wrap spacing uneven (5 and 6 cycles), which exposes any error in carry handling or in the kept remainder.

Pulse widths of 1, 2, 4, 8, 32 and 128 clocks test every bit of the width decoder. An inverted run checks that polarity swaps which level is counted as active.

Directed sequences cover the following:

- the exact edge of the first wrap
- a clear that collides with a set
- a held accumulator while disabled
- a step of zero
- polarity flips with interrupts gated both ways

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Output state machine encoding
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_IDLE    = 2'd1,
        ST_HOLD_HI = 2'd2,
        ST_PULSE   = 2'd3
    } nco_state_e;

    // Raw (pre-polarity) level for a state
    function automatic logic state_active(input nco_state_e s);
        return (s == ST_HOLD_HI) || (s == ST_PULSE);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc_value,
    output logic             wrap
);

    logic [ACC_W:0]   sum_ext;
    logic [ACC_W-1:0] acc_q;

    // One extra bit carries the wrap indication
    assign sum_ext = {1'b0, acc_q} + {1'b0, step};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= sum_ext[ACC_W-1:0];
        end
    end

    assign wrap      = run & sum_ext[ACC_W];
    assign acc_value = acc_q;

endmodule

// File: rtl/nco_wave_fsm.sv
module nco_wave_fsm
    import nco_pkg::*;
#(
    parameter int WSEL_W = 3,
    localparam int CNT_W = (1 << WSEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pulse_mode,
    input  logic [WSEL_W-1:0] width_sel,
    input  logic              wrap,
    output logic              raw_level
);

    nco_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             pulse_done;
    logic             wrap_target_pulse;

    // Thermometer decode: 2^N - 1 has its low N bits set
    for (genvar b = 0; b < CNT_W; b++) begin : g_limit
        assign limit[b] = (int'(width_sel) > b);
    end

    assign pulse_done        = (cnt_q == limit);
    assign wrap_target_pulse = wrap & pulse_mode;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF, ST_IDLE: begin
                    if (wrap)
                        state_d = pulse_mode ? ST_PULSE : ST_HOLD_HI;
                    else
                        state_d = ST_IDLE;
                end
                ST_HOLD_HI: begin
                    if (wrap)
                        state_d = pulse_mode ? ST_PULSE : ST_IDLE;
                end
                ST_PULSE: begin
                    if (wrap)
                        state_d = pulse_mode ? ST_PULSE : ST_IDLE;
                    else if (pulse_done)
                        state_d = ST_IDLE;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wrap_target_pulse)
            cnt_q <= '0;
        else if (state_q == ST_PULSE)
            cnt_q <= cnt_q + 1'b1;
    end

    // Output decode
    always_comb begin
        raw_level = state_active(state_q);
    end

endmodule

// File: rtl/nco_irq_ctrl.sv
module nco_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic irq_enable,
    input  logic invert,
    input  logic wrap,
    input  logic flag_clear,
    output logic irq_flag,
    output logic irq_req
);

    logic invert_q;
    logic pol_flip;
    logic set_evt;
    logic flag_q;

    assign pol_flip = invert ^ invert_q;
    assign set_evt  = wrap | (pol_flip & run & irq_enable);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            invert_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            invert_q <= invert;
            if (set_evt)
                flag_q <= 1'b1;
            else if (flag_clear)
                flag_q <= 1'b0;
        end
    end

    assign irq_flag = flag_q;
    assign irq_req  = flag_q & run & irq_enable;

endmodule

// File: rtl/nco_wavegen.sv
module nco_wavegen #(
    parameter int ACC_W  = 20,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_pulse_mode,
    input  logic              cfg_invert,
    input  logic [WSEL_W-1:0] cfg_width_sel,
    input  logic [ACC_W-1:0]  cfg_step,
    input  logic              cfg_irq_enable,
    input  logic              flag_clear,
    output logic              wave_out,
    output logic              level_status,
    output logic              irq_flag,
    output logic              irq_req
);

    logic [ACC_W-1:0] acc_value;
    logic             acc_wrap;
    logic             raw_level;

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cfg_enable),
        .step      (cfg_step),
        .acc_value (acc_value),
        .wrap      (acc_wrap)
    );

    nco_wave_fsm #(.WSEL_W(WSEL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (cfg_enable),
        .pulse_mode (cfg_pulse_mode),
        .width_sel  (cfg_width_sel),
        .wrap       (acc_wrap),
        .raw_level  (raw_level)
    );

    nco_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (cfg_enable),
        .irq_enable (cfg_irq_enable),
        .invert     (cfg_invert),
        .wrap       (acc_wrap),
        .flag_clear (flag_clear),
        .irq_flag   (irq_flag),
        .irq_req    (irq_req)
    );

    // Polarity is the final stage
    assign wave_out     = raw_level ^ cfg_invert;
    assign level_status = wave_out;

endmodule

// File: rtl/nco_wavegen_chk.sv
module nco_wavegen_chk #(
    parameter int ACC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_pulse_mode,
    input logic             cfg_irq_enable,
    input logic             flag_clear,
    input logic [ACC_W-1:0] acc_value,
    input logic             acc_wrap,
    input logic             raw_level,
    input logic             irq_flag,
    input logic             irq_req
);

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> $stable(acc_value));

    assert_off_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !raw_level);

    assert_pulse_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wrap && cfg_pulse_mode) |=> raw_level);

    assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wrap |=> irq_flag);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clear) |=> irq_flag);

    assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_enable |-> !irq_req);

endmodule

bind nco_wavegen nco_wavegen_chk #(.ACC_W(ACC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_pulse_mode (cfg_pulse_mode),
    .cfg_irq_enable (cfg_irq_enable),
    .flag_clear     (flag_clear),
    .acc_value      (acc_value),
    .acc_wrap       (acc_wrap),
    .raw_level      (raw_level),
    .irq_flag       (irq_flag),
    .irq_req        (irq_req)
);

// File: tb/tb_nco_wavegen.sv
`timescale 1ns/1ps
module tb_nco_wavegen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_pulse_mode = 1'b0;
    logic        cfg_invert = 1'b0;
    logic [2:0]  cfg_width_sel = 3'd0;
    logic [19:0] cfg_step = 20'd0;
    logic        cfg_irq_enable = 1'b0;
    logic        flag_clear = 1'b0;
    logic        wave_out, level_status, irq_flag, irq_req;

    int pass_cnt = 0;
    int fail_cnt = 0;

    always #10 clk = ~clk;   // 50 MHz

    nco_wavegen dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_pulse_mode(cfg_pulse_mode), .cfg_invert(cfg_invert),
        .cfg_width_sel(cfg_width_sel), .cfg_step(cfg_step),
        .cfg_irq_enable(cfg_irq_enable), .flag_clear(flag_clear),
        .wave_out(wave_out), .level_status(level_status),
        .irq_flag(irq_flag), .irq_req(irq_req)
    );

    // Vector table: step, mode, width select, invert, window, expected active samples
    localparam int NV = 11;
    localparam int V_STEP [NV] = '{32'h10000, 32'h20000, 32'h40000, 32'h30000, 32'h10000,
                                   32'h10000, 32'h20000, 32'h04000, 32'h30000, 32'h20000, 32'h01000};
    localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 1};
    localparam int V_WSEL [NV] = '{0, 0, 0, 0, 2, 3, 0, 5, 1, 0, 7};
    localparam int V_INV  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam int V_CYC  [NV] = '{40, 40, 40, 40, 40, 40, 40, 100, 40, 40, 300};
    localparam int V_EXP  [NV] = '{16, 17, 20, 19, 8, 16, 5, 32, 14, 17, 45};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_enable = 1'b0; cfg_pulse_mode = 1'b0; cfg_invert = 1'b0;
        cfg_width_sel = 3'd0; cfg_step = 20'd0; cfg_irq_enable = 1'b0; flag_clear = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int status_bad;
        status_bad = 0;

        // R10: reset state
        do_reset();
        #1;
        check(wave_out == 1'b0 && level_status == 1'b0 && irq_flag == 1'b0 && irq_req == 1'b0,
              "R10", "reset outputs", {wave_out, level_status, irq_flag, irq_req}, 0);

        // Table walk: R2 square wave, R3 pulse, R4 polarity
        for (int v = 0; v < NV; v++) begin
            int active;
            do_reset();
            cfg_step       = V_STEP[v][19:0];
            cfg_pulse_mode = V_MODE[v][0];
            cfg_width_sel  = V_WSEL[v][2:0];
            cfg_invert     = V_INV[v][0];
            cfg_enable     = 1'b1;
            active = 0;
            for (int i = 1; i <= V_CYC[v]; i++) begin
                @(negedge clk);
                if (wave_out == ~V_INV[v][0]) active++;
                if (level_status != wave_out) status_bad++;
            end
            check(active == V_EXP[v], (V_INV[v] != 0) ? "R4" : (V_MODE[v] != 0 ? "R3" : "R2"),
                  $sformatf("vector %0d active samples", v), active, V_EXP[v]);
        end
        check(status_bad == 0, "R8", "status mismatches", status_bad, 0);

        // R1/R5/R7: first wrap edge, stickiness, gating, clear collision
        do_reset();
        cfg_step = 20'h10000;
        cfg_enable = 1'b1;
        repeat (15) @(negedge clk);
        check(irq_flag == 1'b0 && wave_out == 1'b0, "R1", "no wrap before edge 16",
              {irq_flag, wave_out}, 0);
        @(negedge clk);
        check(irq_flag == 1'b1, "R1", "flag on edge 16", irq_flag, 1);
        check(wave_out == 1'b1, "R2", "toggle on wrap edge", wave_out, 1);
        check(irq_req == 1'b0, "R7", "req gated by irq enable", irq_req, 0);
        cfg_irq_enable = 1'b1;
        #1;
        check(irq_req == 1'b1, "R7", "req with both enables", irq_req, 1);
        @(negedge clk);                                  // edge 17
        check(irq_flag == 1'b1, "R5", "flag sticky", irq_flag, 1);
        flag_clear = 1'b1;
        @(negedge clk);                                  // edge 18
        flag_clear = 1'b0;
        check(irq_flag == 1'b0, "R5", "flag cleared", irq_flag, 0);
        repeat (13) @(negedge clk);                      // edge 31
        flag_clear = 1'b1;
        @(negedge clk);                                  // edge 32 wraps
        flag_clear = 1'b0;
        check(irq_flag == 1'b1, "R5", "set wins over clear", irq_flag, 1);
        check(wave_out == 1'b0, "R2", "second toggle", wave_out, 0);
        cfg_enable = 1'b0;
        #1;
        check(irq_req == 1'b0, "R7", "req gated by module enable", irq_req, 0);

        // R9: hold while disabled
        do_reset();
        cfg_step = 20'h10000;
        cfg_enable = 1'b1;
        repeat (8) @(negedge clk);
        cfg_enable = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (wave_out != 1'b0) bad++;
            end
            check(bad == 0, "R9", "inactive while disabled", bad, 0);
        end
        check(irq_flag == 1'b0, "R9", "no wrap while disabled", irq_flag, 0);
        cfg_invert = 1'b1;
        #1;
        check(wave_out == 1'b1, "R4", "inverted inactive level", wave_out, 1);
        @(negedge clk);
        cfg_invert = 1'b0;
        @(negedge clk);
        check(irq_flag == 1'b0, "R6", "polarity flip while disabled", irq_flag, 0);
        cfg_enable = 1'b1;
        repeat (7) @(negedge clk);
        check(wave_out == 1'b0, "R9", "resume not yet wrapped", wave_out, 0);
        @(negedge clk);
        check(wave_out == 1'b1, "R9", "resume wraps after held half", wave_out, 1);

        // R1 zero step, R6 polarity interrupt
        do_reset();
        cfg_enable = 1'b1;
        repeat (100) @(negedge clk);
        check(irq_flag == 1'b0 && wave_out == 1'b0, "R1", "zero step never wraps",
              {irq_flag, wave_out}, 0);
        cfg_invert = 1'b1;
        @(negedge clk);
        check(irq_flag == 1'b0, "R6", "flip without irq enable", irq_flag, 0);
        check(wave_out == 1'b1, "R4", "inactive high when inverted", wave_out, 1);
        cfg_irq_enable = 1'b1;
        cfg_invert = 1'b0;
        @(negedge clk);
        check(irq_flag == 1'b1, "R6", "flip with irq enable sets flag", irq_flag, 1);
        check(irq_req == 1'b1, "R7", "req after polarity flip", irq_req, 1);

        finish_run();
    end

endmodule